// File: doc/BRIEF.md
# Cascadable Eight-Bit ALU Slice with Condition Flags

This block is a purely combinational arithmetic logic unit slice. It has two operand buses, a three-bit operation code and one carry/fill bit. It returns a result bus and four condition flags: carry, zero, sign and overflow. Every output follows its inputs within the same cycle. The slice holds no state and needs no clock or reset.

One input bit does two jobs. It is the carry into the adder for the two add operations. It is also the bit shifted into the vacated end for the two shift operations. The carry flag then carries the bit that leaves the slice: the adder carry or the bit shifted off the operand. Because of this, four slices can be chained into a 32-bit unit, with each slice's carry flag feeding the carry/fill input of its neighbour. Subtraction of A from B uses the inverted-add operation with the carry input set to 1.

Top module: `alu_slice`

## Requirements
- R1: Op code 000 gives result = B + A + carry_in, modulo 2^WIDTH.
- R2: Op code 001 gives result = B + (~A) + carry_in. With carry_in = 1 this is B - A.
- R3: Op code 010 gives result = A AND B, bit by bit.
- R4: Op code 011 gives result = A XOR B, bit by bit.
- R5: Op code 100 shifts A right by one place. carry_in enters the top bit (bit WIDTH-1), and flag_carry equals A[0].
- R6: Op code 101 shifts A left by one place. carry_in enters bit 0, and flag_carry equals A[WIDTH-1].
- R7: For op codes 000 and 001, flag_carry is the carry out of the top adder bit. For op codes 010 and 011, flag_carry is 0.
- R8: For every op code, flag_zero is 1 exactly when every bit of the result is 0.
- R9: For every op code, flag_sign equals the top bit of the result.
- R10: For op codes 000 and 001, flag_ovf is 1 when the two adder inputs (B, and A or ~A) have equal top bits and the result's top bit differs from them. For every other op code, flag_ovf is 0.
- R11: Op codes 110 and 111 give result = 0, flag_carry = 0 and flag_ovf = 0. As a consequence, flag_zero = 1 and flag_sign = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH | First operand; the one inverted, shifted and added |
| opnd_b | input | WIDTH | Second operand |
| carry_in | input | 1 | Adder carry in and shift fill bit |
| op_sel | input | 3 | Operation code |
| result | output | WIDTH | Operation result |
| flag_carry | output | 1 | Carry out, or the bit shifted off the operand |
| flag_zero | output | 1 | Result is all zeros |
| flag_sign | output | 1 | Top bit of the result |
| flag_ovf | output | 1 | Signed overflow of the add operations |

## Verification
The bench builds the slice with WIDTH = 8, the width used for chaining. At this width the operand values 0x00, 0x7F, 0x80 and 0xFF are exactly the signed and unsigned overflow edges. All eight op code values, including the two unused ones, are crossed with these edge values and with both carry_in levels. Fixed-seed random operands then cover the interior of the adder carry chain.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned OP_W = 3;
  localparam logic [OP_W-1:0] OP_ADD  = 3'b000;
  localparam logic [OP_W-1:0] OP_ADDN = 3'b001;
  localparam logic [OP_W-1:0] OP_AND  = 3'b010;
  localparam logic [OP_W-1:0] OP_XOR  = 3'b011;
  localparam logic [OP_W-1:0] OP_SHR  = 3'b100;
  localparam logic [OP_W-1:0] OP_SHL  = 3'b101;
endpackage

// File: rtl/alu_ripple_adder.sv
module alu_ripple_adder #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] aug,
  input  logic [WIDTH-1:0] addend,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             ovf
);
  localparam int unsigned EXT = WIDTH + 1;

  logic [WIDTH:0] cy;
  assign cy[0] = cin;

  for (genvar i = 0; i < WIDTH; i++) begin : g_fa
    assign sum[i]  = aug[i] ^ addend[i] ^ cy[i];
    assign cy[i+1] = (aug[i] & addend[i]) | (cy[i] & (aug[i] ^ addend[i]));
  end

  assign cout = cy[WIDTH];
  assign ovf  = cy[WIDTH] ^ cy[WIDTH-1];

  always_comb begin
    assert_sum_R1: assert ({cout, sum} == EXT'({1'b0, aug}) + EXT'({1'b0, addend}) + EXT'(cin))
      else $error("ripple sum mismatch");
    assert_ovf_R10: assert (ovf == ((aug[WIDTH-1] == addend[WIDTH-1]) && (sum[WIDTH-1] != aug[WIDTH-1])))
      else $error("overflow rule mismatch");
  end
endmodule

// File: rtl/alu_bitops.sv
module alu_bitops #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             fill,
  output logic [WIDTH-1:0] and_r,
  output logic [WIDTH-1:0] xor_r,
  output logic [WIDTH-1:0] shr_r,
  output logic [WIDTH-1:0] shl_r
);
  assign and_r = a & b;
  assign xor_r = a ^ b;
  assign shr_r = {fill, a[WIDTH-1:1]};
  assign shl_r = {a[WIDTH-2:0], fill};
endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] res,
  output logic             zf,
  output logic             sf
);
  assign zf = ~|res;
  assign sf = res[WIDTH-1];
endmodule

// File: rtl/alu_slice.sv
module alu_slice #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0]         opnd_a,
  input  logic [WIDTH-1:0]         opnd_b,
  input  logic                     carry_in,
  input  logic [alu_pkg::OP_W-1:0] op_sel,
  output logic [WIDTH-1:0]         result,
  output logic                     flag_carry,
  output logic                     flag_zero,
  output logic                     flag_sign,
  output logic                     flag_ovf
);
  import alu_pkg::*;

  logic [WIDTH-1:0] add_in_a, add_sum, and_r, xor_r, shr_r, shl_r;
  logic             add_co, add_ov;

  assign add_in_a = (op_sel == OP_ADDN) ? ~opnd_a : opnd_a;

  alu_ripple_adder #(.WIDTH(WIDTH)) u_add (
    .aug(opnd_b), .addend(add_in_a), .cin(carry_in),
    .sum(add_sum), .cout(add_co), .ovf(add_ov)
  );

  alu_bitops #(.WIDTH(WIDTH)) u_bit (
    .a(opnd_a), .b(opnd_b), .fill(carry_in),
    .and_r(and_r), .xor_r(xor_r), .shr_r(shr_r), .shl_r(shl_r)
  );

  always_comb begin
    result     = '0;
    flag_carry = 1'b0;
    flag_ovf   = 1'b0;
    unique case (op_sel)
      OP_ADD, OP_ADDN: begin
        result     = add_sum;
        flag_carry = add_co;
        flag_ovf   = add_ov;
      end
      OP_AND: result = and_r;
      OP_XOR: result = xor_r;
      OP_SHR: begin
        result     = shr_r;
        flag_carry = opnd_a[0];
      end
      OP_SHL: begin
        result     = shl_r;
        flag_carry = opnd_a[WIDTH-1];
      end
      default: ;
    endcase
  end

  alu_flag_gen #(.WIDTH(WIDTH)) u_flags (
    .res(result), .zf(flag_zero), .sf(flag_sign)
  );

  always_comb begin
    if (op_sel == OP_SHR)
      assert_shr_R5: assert ({result, flag_carry} == {carry_in, opnd_a})
        else $error("right shift mismatch");
    if (op_sel == OP_SHL)
      assert_shl_R6: assert ({flag_carry, result} == {opnd_a, carry_in})
        else $error("left shift mismatch");
    if (op_sel == OP_AND || op_sel == OP_XOR)
      assert_carry_clear_R7: assert (!flag_carry) else $error("carry set on logic op");
    if (op_sel != OP_ADD && op_sel != OP_ADDN)
      assert_no_overflow_R10: assert (!flag_ovf) else $error("overflow on non-add op");
    assert_zero_R8: assert (flag_zero == (result == '0)) else $error("zero flag mismatch");
    if (flag_zero)
      assert_sign_R9: assert (!flag_sign) else $error("sign set on zero result");
    if (op_sel[2:1] == 2'b11)
      assert_unused_R11: assert (result == '0 && !flag_carry && flag_zero)
        else $error("unused op not cleared");
  end
endmodule

// File: tb/tb_alu_slice.sv
module tb_alu_slice;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [7:0] a, b, f;
  logic [2:0] op;
  logic       cin, co, zf, sf, of;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  alu_slice #(.WIDTH(8)) dut (
    .opnd_a(a), .opnd_b(b), .carry_in(cin), .op_sel(op),
    .result(f), .flag_carry(co), .flag_zero(zf), .flag_sign(sf), .flag_ovf(of)
  );

  function automatic logic [11:0] ref_model(logic [7:0] x, logic [7:0] y, logic [2:0] o, logic c);
    logic [8:0] s;
    logic [7:0] r, xa;
    logic       rc, rv;
    r = '0; rc = 1'b0; rv = 1'b0;
    case (o)
      3'd0, 3'd1: begin
        xa = (o == 3'd1) ? ~x : x;
        s  = {1'b0, y} + {1'b0, xa} + {8'd0, c};
        r  = s[7:0]; rc = s[8];
        rv = (xa[7] == y[7]) && (r[7] != y[7]);
      end
      3'd2: r = x & y;
      3'd3: r = x ^ y;
      3'd4: begin r = {c, x[7:1]}; rc = x[0]; end
      3'd5: begin r = {x[6:0], c}; rc = x[7]; end
      default: ;
    endcase
    return {r, rc, (r == 8'd0), r[7], rv};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s op=%0d a=%h b=%h cin=%0d actual=%h expected=%h", tag, op, a, b, cin, act, exp);
    end
  endtask

  task automatic apply(logic [7:0] x, logic [7:0] y, logic [2:0] o, logic c);
    logic [11:0] e;
    string ftag;
    @(posedge clk);
    a = x; b = y; op = o; cin = c;
    @(negedge clk);
    e = ref_model(x, y, o, c);
    case (o)
      3'd0: ftag = "R1"; 3'd1: ftag = "R2"; 3'd2: ftag = "R3";
      3'd3: ftag = "R4"; 3'd4: ftag = "R5"; 3'd5: ftag = "R6";
      default: ftag = "R11";
    endcase
    chk(ftag, 32'(f), 32'(e[11:4]));
    chk((o >= 3'd4 && o <= 3'd5) ? ftag : "R7", 32'(co), 32'(e[3]));
    chk("R8", 32'(zf), 32'(e[2]));
    chk("R9", 32'(sf), 32'(e[1]));
    chk("R10", 32'(of), 32'(e[0]));
  endtask

  initial begin
    logic [7:0] corner [4];
    corner[0] = 8'h00; corner[1] = 8'h7F; corner[2] = 8'h80; corner[3] = 8'hFF;
    a = '0; b = '0; op = '0; cin = 1'b0;
    void'($urandom(32'd20240611));
    @(negedge clk);
    chk("R8", 32'(zf), 32'd1);
    chk("R1", 32'(f), 32'd0);
    // R2 directed: 10 - 3 = 7, no borrow so carry is 1
    apply(8'd3, 8'd10, 3'd1, 1'b1);
    chk("R2", 32'(f), 32'h07);
    chk("R7", 32'(co), 32'd1);
    // R1/R10 directed: 0x7F + 0x01 overflows to 0x80
    apply(8'h01, 8'h7F, 3'd0, 1'b0);
    chk("R10", 32'(of), 32'd1);
    chk("R9", 32'(sf), 32'd1);
    for (int o = 0; o < 8; o++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          for (int c = 0; c < 2; c++)
            apply(corner[i], corner[j], 3'(o), 1'(c));
    for (int n = 0; n < 1500; n++)
      apply(8'($urandom), 8'($urandom), 3'($urandom), 1'($urandom));
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule